// File: doc/BRIEF.md
# Overlapped Matrix Multiply-Accumulate Engine

This block is a command-driven accelerator. It holds three K x K fixed-point matrices, called A, B and C, and computes C = C + A*B. A host side feeds it a stream of four commands: load A, load B, multiply-accumulate and store C. Matrix words come in one per transfer on an inbound valid/ready stream. C leaves one word per transfer on an outbound valid/ready stream. B is supplied already transposed, so the multiply walks both operands along the same inner index.

Three sequencers share the work. One loads A or B, one computes and one stores C. Each sequencer owns its own storage ports, so all three can be busy at once. Every matrix element has a pending bit. The bit is set when a command that will produce the element is accepted, and it is cleared by the element's final write. A consumer waits on a pending element, so a read never overtakes the write it depends on. For the reverse hazard, a command that would overwrite a matrix is held back while an earlier reader of that matrix is still running.

Operands are signed Q8.8 values of 16 bits. C accumulates in 32 bits in Q16.16. A store returns bits [23:8] of each accumulator, which is Q8.8 with wrap on overflow. K must be a power of two. The default is K = 4.

Top module: `mac_engine`

## Requirements
- R1: After reset, cmd_ready is 1 while every sequencer is idle, in_ready is 0, out_valid is 0, and every C element reads as zero.
- R2: LoadA (cmd_op = 0) takes exactly K*K inbound words, and word number i*K+j becomes A(i,j). in_ready is 0 whenever no load is running, and words offered at that time are not taken.
- R3: LoadB (cmd_op = 1) takes K*K words, and word number j*K+k becomes B(j,k). B is therefore given transposed.
- R4: MultAccum (cmd_op = 3) adds the sum over k of A(i,k)*B(j,k) to C(i,j) for every i and j. Each product is a full Q16.16 product, and the sum wraps modulo 2^32.
- R5: StoreC (cmd_op = 2) emits exactly K*K words in the order i*K+j. Each word is bits [23:8] of the C accumulator.
- R6: C keeps its value between commands, so repeated MultAccum commands accumulate. Only reset clears C.
- R7: A MultAccum is accepted while a LoadB is still receiving words. The MultAccum still uses only operand elements that have already been written.
- R8: A StoreC is accepted while the preceding MultAccum is still running. Each C word is emitted only after its final accumulate.
- R9: LoadA and LoadB are not accepted while a MultAccum is running. A MultAccum is not accepted while a StoreC is running.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command can be accepted this cycle |
| cmd_op | input | 2 | Command code: 0 LoadA, 1 LoadB, 2 StoreC, 3 MultAccum |
| in_valid | input | 1 | An inbound matrix word is offered |
| in_ready | output | 1 | A load is running and will take the word |
| in_data | input | DW | Inbound matrix word, Q8.8 |
| out_valid | output | 1 | An outbound C word is available |
| out_ready | input | 1 | The receiver takes the outbound word |
| out_data | output | DW | Outbound C word, Q8.8 |

## Verification
The main function is exercised with several operand patterns:

- An identity A against a random B gives C(i,j) = B(j,i), which exposes any mix-up of the transposed B order.
- An identity B against a random A exposes errors in the A row order.
- A second multiply with no reload tells accumulation apart from overwrite.
- All-minimum and all-maximum operands expose sign-extension and wrap errors.
- Random data with a sparse inbound stream and a stalling receiver forces the three sequencers to overlap.

In the overlapped run, the bench compares the cycle in which each command is accepted against the cycles of the last load word and the last store word. This separates correct overlap from serialisation on one side and from hazard violations on the other.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_A   = 2'd0,
        OP_LOAD_B   = 2'd1,
        OP_STORE_C  = 2'd2,
        OP_MULT_ACC = 2'd3
    } mac_op_e;
endpackage

// File: rtl/mac_matrix_store.sv
// Register-based matrix storage with one write port, NRD read ports and a
// pending bit per element that a producer sets in bulk and clears per write.
module mac_matrix_store #(
    parameter int W   = 16,
    parameter int N   = 16,
    parameter int NRD = 1,
    parameter int IW  = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_all,
    input  logic                     we,
    input  logic [IW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic                     wclr,
    input  logic [NRD-1:0][IW-1:0]   raddr,
    output logic [NRD-1:0][W-1:0]    rdata,
    output logic [NRD-1:0]           rpend
);
    typedef struct packed {
        logic [N-1:0][W-1:0] mem;
        logic [N-1:0]        pend;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_all) begin
            st_d.pend = '1;
        end
        if (we) begin
            st_d.mem[waddr] = wdata;
            if (wclr) begin
                st_d.pend[waddr] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = st_q.mem[raddr[r]];
        assign rpend[r] = st_q.pend[raddr[r]];
    end
endmodule

// File: rtl/mac_compute.sv
// Triple-loop multiply-accumulate sequencer: one step per cycle over i, j, k,
// stalling while either operand element is still pending.
module mac_compute #(
    parameter int K  = 4,
    parameter int DW = 16,
    parameter int CW = 32,
    parameter int LK = $clog2(K)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   a_data,
    input  logic            a_pend,
    input  logic [DW-1:0]   b_data,
    input  logic            b_pend,
    input  logic [CW-1:0]   c_data,
    output logic            busy,
    output logic [2*LK-1:0] a_addr,
    output logic [2*LK-1:0] b_addr,
    output logic [2*LK-1:0] c_addr,
    output logic            c_we,
    output logic [CW-1:0]   c_wdata,
    output logic            c_last
);
    localparam int SW = 3 * LK;

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] step;
    } cmp_t;

    cmp_t cq, cd;

    logic [LK-1:0] idx_i, idx_j, idx_k;
    logic [CW-1:0] a_ext, b_ext, prod;
    logic          go;

    assign idx_i  = cq.step[3*LK-1:2*LK];
    assign idx_j  = cq.step[2*LK-1:LK];
    assign idx_k  = cq.step[LK-1:0];
    assign a_addr = {idx_i, idx_k};
    assign b_addr = {idx_j, idx_k};
    assign c_addr = {idx_i, idx_j};

    assign a_ext   = {{(CW-DW){a_data[DW-1]}}, a_data};
    assign b_ext   = {{(CW-DW){b_data[DW-1]}}, b_data};
    assign prod    = a_ext * b_ext;
    assign go      = cq.busy && !a_pend && !b_pend;
    assign c_we    = go;
    assign c_wdata = c_data + prod;
    assign c_last  = (idx_k == LK'(K-1));
    assign busy    = cq.busy;

    always_comb begin
        cd = cq;
        if (start) begin
            cd.busy = 1'b1;
            cd.step = '0;
        end else if (go) begin
            cd.step = cq.step + SW'(1);
            if (&cq.step) begin
                cd.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq <= '0;
        end else begin
            cq <= cd;
        end
    end
endmodule

// File: rtl/mac_engine.sv
// Command dispatch, load sequencer and store sequencer around three matrix
// stores and the compute sequencer.
module mac_engine
    import mac_pkg::*;
#(
    parameter int K    = 4,
    parameter int DW   = 16,
    parameter int CW   = 32,
    parameter int FRAC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int KK = K * K;
    localparam int IW = $clog2(KK);

    typedef struct packed {
        logic          ld_busy;
        logic          ld_sel_b;
        logic [IW-1:0] ld_idx;
        logic          st_busy;
        logic [IW-1:0] st_idx;
    } seq_t;

    seq_t q, d;

    mac_op_e op;
    logic    accept, fire, in_fire, out_fire;
    logic    is_load, a_set, b_set, c_set;
    logic    cmp_busy, st_busy, c_we, c_last;
    logic    a_rpend, b_rpend;
    logic    unused_bits;

    logic [IW-1:0]         a_addr, b_addr, c_addr;
    logic [DW-1:0]         a_rd, b_rd;
    logic [1:0][CW-1:0]    c_rd;
    logic [1:0]            c_rpend;
    logic [CW-1:0]         c_wdata;

    assign op = mac_op_e'(cmd_op);

    always_comb begin
        case (op)
            OP_LOAD_A, OP_LOAD_B: accept = !q.ld_busy && !cmp_busy;
            OP_STORE_C:           accept = !q.st_busy;
            default:              accept = !cmp_busy && !q.st_busy;
        endcase
    end

    assign cmd_ready = accept;
    assign fire      = cmd_valid && accept;
    assign is_load   = (op == OP_LOAD_A) || (op == OP_LOAD_B);
    assign a_set     = fire && (op == OP_LOAD_A);
    assign b_set     = fire && (op == OP_LOAD_B);
    assign c_set     = fire && (op == OP_MULT_ACC);

    assign in_ready  = q.ld_busy;
    assign in_fire   = in_valid && q.ld_busy;
    assign out_valid = q.st_busy && !c_rpend[1];
    assign out_fire  = out_valid && out_ready;
    assign out_data  = c_rd[1][FRAC +: DW];
    assign st_busy   = q.st_busy;

    assign unused_bits = ^{c_rd[1][CW-1:FRAC+DW], c_rd[1][FRAC-1:0], c_rpend[0]};

    always_comb begin
        d = q;
        if (fire && is_load) begin
            d.ld_busy  = 1'b1;
            d.ld_sel_b = cmd_op[0];
            d.ld_idx   = '0;
        end else if (in_fire) begin
            d.ld_idx = q.ld_idx + IW'(1);
            if (q.ld_idx == IW'(KK-1)) begin
                d.ld_busy = 1'b0;
            end
        end
        if (fire && (op == OP_STORE_C)) begin
            d.st_busy = 1'b1;
            d.st_idx  = '0;
        end else if (out_fire) begin
            d.st_idx = q.st_idx + IW'(1);
            if (q.st_idx == IW'(KK-1)) begin
                d.st_busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    mac_matrix_store #(.W(DW), .N(KK), .NRD(1)) i_store_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (a_set),
        .we      (in_fire && !q.ld_sel_b),
        .waddr   (q.ld_idx),
        .wdata   (in_data),
        .wclr    (1'b1),
        .raddr   (a_addr),
        .rdata   (a_rd),
        .rpend   (a_rpend)
    );

    mac_matrix_store #(.W(DW), .N(KK), .NRD(1)) i_store_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (b_set),
        .we      (in_fire && q.ld_sel_b),
        .waddr   (q.ld_idx),
        .wdata   (in_data),
        .wclr    (1'b1),
        .raddr   (b_addr),
        .rdata   (b_rd),
        .rpend   (b_rpend)
    );

    mac_matrix_store #(.W(CW), .N(KK), .NRD(2)) i_store_c (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (c_set),
        .we      (c_we),
        .waddr   (c_addr),
        .wdata   (c_wdata),
        .wclr    (c_last),
        .raddr   ({q.st_idx, c_addr}),
        .rdata   (c_rd),
        .rpend   (c_rpend)
    );

    mac_compute #(.K(K), .DW(DW), .CW(CW)) i_compute (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (c_set),
        .a_data  (a_rd),
        .a_pend  (a_rpend),
        .b_data  (b_rd),
        .b_pend  (b_rpend),
        .c_data  (c_rd[0]),
        .busy    (cmp_busy),
        .a_addr  (a_addr),
        .b_addr  (b_addr),
        .c_addr  (c_addr),
        .c_we    (c_we),
        .c_wdata (c_wdata),
        .c_last  (c_last)
    );
endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
    parameter int K  = 4,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_op,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          cmp_busy,
    input logic          st_busy,
    input logic          c_we,
    input logic          a_pend,
    input logic          b_pend
);
    localparam int KK   = K * K;
    localparam int CNTW = $clog2(KK) + 1;

    logic [CNTW-1:0] out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt <= '0;
        end else if (out_valid && out_ready) begin
            out_cnt <= out_cnt + CNTW'(1);
        end else if (!st_busy) begin
            out_cnt <= '0;
        end
    end

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_load_war_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_op[1] && cmp_busy |-> !cmd_ready);

    p_mac_war_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 2'd3) && st_busy |-> !cmd_ready);

    p_operand_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> !a_pend && !b_pend);

    p_store_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_busy) |-> out_cnt == CNTW'(KK));
endmodule

bind mac_engine mac_engine_chk #(.K(K), .DW(DW)) i_mac_engine_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cmp_busy  (cmp_busy),
    .st_busy   (st_busy),
    .c_we      (c_we),
    .a_pend    (a_rpend),
    .b_pend    (b_rpend)
);

// File: tb/test_mac_engine.sv
module test_mac_engine;
    localparam int K  = 4;
    localparam int KK = K * K;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    mac_engine #(.K(K)) i_mac_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;

    logic [15:0] ea [KK];
    logic [15:0] eb [KK];
    logic [31:0] ec [KK];

    int          p_op [32];
    int          n_cmd;
    logic [15:0] p_in [512];
    int          n_in;
    logic [15:0] p_exp [256];
    int          n_exp;
    int          acc_cyc [32];
    int          ld_done [32];
    int          n_ld;
    int          out_cyc [256];
    int          in_prob = 100;
    int          out_prob = 100;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] gen(input int kind, input int idx);
        case (kind)
            1: return ((idx / K) == (idx % K)) ? 16'h0100 : 16'h0000;
            2: return 16'h8000;
            3: return 16'h7FFF;
            4: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic clear_prog();
        n_cmd = 0; n_in = 0; n_exp = 0; n_ld = 0;
    endtask

    task automatic add_load(input bit isb, input int kind);
        for (int x = 0; x < KK; x++) begin
            logic [15:0] w;
            w = gen(kind, x);
            p_in[n_in] = w;
            n_in++;
            if (isb) eb[x] = w; else ea[x] = w;
        end
        p_op[n_cmd] = isb ? 1 : 0;
        n_cmd++;
    endtask

    task automatic add_mac();
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++) begin
                logic [31:0] acc;
                acc = ec[i*K+j];
                for (int k = 0; k < K; k++) begin
                    logic [31:0] xa, xb;
                    xa = {{16{ea[i*K+k][15]}}, ea[i*K+k]};
                    xb = {{16{eb[j*K+k][15]}}, eb[j*K+k]};
                    acc = acc + xa * xb;
                end
                ec[i*K+j] = acc;
            end
        end
        p_op[n_cmd] = 3;
        n_cmd++;
    endtask

    task automatic add_store();
        for (int x = 0; x < KK; x++) begin
            p_exp[n_exp] = ec[x][23:8];
            n_exp++;
        end
        p_op[n_cmd] = 2;
        n_cmd++;
    endtask

    task automatic cmd_thread();
        for (int n = 0; n < n_cmd; n++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op = 2'(p_op[n]);
            #1;
            while (!cmd_ready) begin
                @(negedge clk);
                #1;
            end
            acc_cyc[n] = cyc;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic feed_thread();
        int idx;
        idx = 0;
        while (idx < n_in) begin
            @(negedge clk);
            in_valid = ($urandom_range(99) < in_prob);
            in_data = p_in[idx];
            #1;
            if (in_valid && in_ready) begin
                idx++;
                if (idx % KK == 0) begin
                    ld_done[n_ld] = cyc;
                    n_ld++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_thread(input string req);
        int          idx;
        bit          hold;
        logic [15:0] hold_data;
        idx = 0;
        hold = 1'b0;
        hold_data = '0;
        while (idx < n_exp) begin
            @(negedge clk);
            if (hold) begin
                chk(out_valid === 1'b1, "R10", "valid held", int'(out_valid), 1);
                chk(out_data === hold_data, "R10", "data held", int'(out_data), int'(hold_data));
            end
            out_ready = ($urandom_range(99) < out_prob);
            #1;
            hold = out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid && out_ready) begin
                chk(out_data === p_exp[idx], req, $sformatf("word %0d", idx),
                    int'(out_data), int'(p_exp[idx]));
                out_cyc[idx] = cyc;
                idx++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_prog(input string req);
        fork
            cmd_thread();
            feed_thread();
            drain_thread(req);
        join
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int x = 0; x < KK; x++) begin
            ea[x] = '0; eb[x] = '0; ec[x] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        chk(cmd_ready === 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
        chk(in_ready === 1'b0, "R1", "in_ready", int'(in_ready), 0);
        chk(out_valid === 1'b0, "R1", "out_valid", int'(out_valid), 0);

        // R1 and R5: C reads back as zero after reset
        clear_prog();
        add_store();
        run_prog("R1 R5");

        // R3: identity A, random B gives C(i,j) = B(j,i)
        clear_prog();
        add_load(1'b0, 1);
        add_load(1'b1, 0);
        add_mac();
        add_store();
        run_prog("R3");

        // R2: identity B, random A, with gaps and stalls
        in_prob = 70; out_prob = 60;
        clear_prog();
        add_load(1'b1, 1);
        add_load(1'b0, 0);
        add_mac();
        add_store();
        run_prog("R2");

        // R6: multiply again without reload accumulates
        clear_prog();
        add_mac();
        add_store();
        run_prog("R6");

        // R4: extreme operands, wrap, then random signed data
        in_prob = 100; out_prob = 100;
        clear_prog();
        add_load(1'b0, 2);
        add_load(1'b1, 2);
        add_mac();
        add_store();
        add_load(1'b0, 3);
        add_load(1'b1, 3);
        add_mac();
        add_store();
        add_load(1'b0, 0);
        add_load(1'b1, 0);
        add_mac();
        add_store();
        run_prog("R4");

        // R7 R8 R9: overlapped program with a slow inbound stream
        in_prob = 30; out_prob = 50;
        clear_prog();
        add_load(1'b0, 0);
        add_load(1'b1, 0);
        add_mac();
        add_store();
        add_load(1'b0, 0);
        add_load(1'b1, 0);
        add_mac();
        add_store();
        run_prog("R8");
        chk(acc_cyc[2] < ld_done[1], "R7", "mac accepted before B load done",
            acc_cyc[2], ld_done[1]);
        chk(acc_cyc[3] < ld_done[1], "R8", "store accepted before B load done",
            acc_cyc[3], ld_done[1]);
        chk(acc_cyc[4] >= ld_done[1] + 48, "R9", "load held while mac runs",
            acc_cyc[4], ld_done[1] + 48);
        chk(acc_cyc[6] > out_cyc[KK-1], "R9", "mac held while store runs",
            acc_cyc[6], out_cyc[KK-1] + 1);

        // R2: inbound words with no load in progress are not taken
        in_prob = 100; out_prob = 100;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 16'h5A5A;
        for (int n = 0; n < 4; n++) begin
            #1;
            chk(in_ready === 1'b0, "R2", "in_ready idle", int'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        clear_prog();
        add_store();
        run_prog("R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule